// File: doc/BRIEF.md
# Associative Register Rename Table

This block maps architectural register numbers to physical register numbers for an out-of-order core. It keeps one entry per physical register. Each entry records which architectural register it stands for, plus two flags: a speculative flag (the entry is the newest mapping seen at rename) and a retired flag (the entry is the mapping that in-order retirement has made architectural). A source lookup compares the requested architectural number against every entry whose speculative flag is set. The single hit is encoded into a binary physical register number.

Each cycle the table serves two source lookups, one destination rename and one retirement. A rename picks the lowest-numbered free entry, tags it with the destination register and moves the speculative flag onto it. A retirement names the physical entry being retired and moves the retired flag onto it in the same way. A rollback input copies every retired flag over the speculative flag in one cycle, which undoes all renames that have not retired. An entry counts as in flight from rename until its retirement. It is free only when neither flag is set and it is not in flight.

The control is not a sequential state machine. Each cycle the top decodes one of two modes: `MODE_ROLLBACK` when the rollback input is high, and `MODE_NORMAL` otherwise. In normal mode the rename and the retirement both take effect.

Top module: `rename_cam_table`

## Requirements
- R1: After reset, architectural register i (for i below NUM_ARCH) maps to physical register i. Lookups of every architectural register return it with the error flag low, and entries NUM_ARCH and above are free.
- R2: Both lookup ports return, in the same cycle and combinationally, the physical number (the entry index) whose speculative flag is set for the requested architectural register. The error flag is high only when the number of such entries is not exactly one.
- R3: A rename with `rn_ok` high allocates the lowest-indexed free entry and shows it on `rn_phys`, with the replaced mapping on `rn_prev_phys`. From the next cycle on, lookups of that register return the new entry.
- R4: A lookup of a register that is renamed in the same cycle returns the mapping from before that rename.
- R5: An entry that has been renamed and then superseded by a later rename, but has not retired, is not handed out again.
- R6: Retiring an in-flight entry sets its retired flag and clears the retired flag of the earlier retired entry for the same register. That earlier entry becomes free once it no longer holds the speculative flag.
- R7: Rollback makes every speculative flag equal to its retired flag and clears all in-flight marks in one cycle. Rename and retirement in that cycle are ignored, and from the next cycle lookups return the retired mappings.
- R8: `rn_ok` is low exactly when no entry is free. A rename request while it is low changes no mapping.
- R9: A retirement that names an entry which is not in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_arch_a | input | ARCH_W | Source register for lookup port A |
| lk_arch_b | input | ARCH_W | Source register for lookup port B |
| lk_phys_a | output | PHYS_W | Physical number found by port A |
| lk_phys_b | output | PHYS_W | Physical number found by port B |
| lk_err_a | output | 1 | Port A hit count is not exactly one |
| lk_err_b | output | 1 | Port B hit count is not exactly one |
| rn_valid | input | 1 | Rename a destination this cycle |
| rn_arch | input | ARCH_W | Destination architectural register |
| rn_ok | output | 1 | A free entry exists |
| rn_phys | output | PHYS_W | Entry that the rename will take |
| rn_prev_phys | output | PHYS_W | Current mapping of the destination |
| cm_valid | input | 1 | Retire a mapping this cycle |
| cm_phys | input | PHYS_W | Physical entry being retired |
| recover | input | 1 | Roll speculative mappings back to retired ones |

## Verification
The hardest state to reach is a fully allocated table with a mix of retired, superseded-but-in-flight and rolled-back entries, because only long rename sequences with no retirement in between exhaust the free pool. The bench first runs a table of renames and retirements that leaves superseded entries in flight (for R5) and frees retired ones (for R6). It then rolls back and renames one register until `rn_ok` drops. After that it rolls back again and retires a stale, no-longer-in-flight entry whose tag still names that register, so that a wrongly accepted retirement would show up in the mapping after a further rollback.

// File: rtl/rename_cam_pkg.sv
package rename_cam_pkg;

    typedef enum logic [0:0] {
        MODE_NORMAL   = 1'b0,
        MODE_ROLLBACK = 1'b1
    } cam_mode_e;

endpackage

// File: rtl/rename_cam_match.sv
module rename_cam_match #(
    parameter int NUM_ENTRIES = 16,
    parameter int TAG_W       = 3,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic [TAG_W-1:0]                   key,
    input  logic [NUM_ENTRIES-1:0][TAG_W-1:0]  tags,
    input  logic [NUM_ENTRIES-1:0]             qual,
    output logic [IDX_W-1:0]                   idx,
    output logic                               err
);

    logic [NUM_ENTRIES-1:0] hit;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign hit[g] = qual[g] && (tags[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (hit[i]) idx = idx | IDX_W'(i);
        end
    end

    assign err = (hit == '0) || ((hit & (hit - 1'b1)) != '0);

endmodule

// File: rtl/rename_cam_free_scan.sv
module rename_cam_free_scan #(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] avail,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (avail[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rename_cam_table.sv
module rename_cam_table #(
    parameter int NUM_PHYS = 16,
    parameter int NUM_ARCH = 8,
    parameter int ARCH_W   = $clog2(NUM_ARCH),
    parameter int PHYS_W   = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARCH_W-1:0] lk_arch_a,
    input  logic [ARCH_W-1:0] lk_arch_b,
    output logic [PHYS_W-1:0] lk_phys_a,
    output logic [PHYS_W-1:0] lk_phys_b,
    output logic              lk_err_a,
    output logic              lk_err_b,
    input  logic              rn_valid,
    input  logic [ARCH_W-1:0] rn_arch,
    output logic              rn_ok,
    output logic [PHYS_W-1:0] rn_phys,
    output logic [PHYS_W-1:0] rn_prev_phys,
    input  logic              cm_valid,
    input  logic [PHYS_W-1:0] cm_phys,
    input  logic              recover
);
    import rename_cam_pkg::*;

    localparam int LOOKUP_PORTS = 2;

    logic [NUM_PHYS-1:0][ARCH_W-1:0] tag_q, tag_d;
    logic [NUM_PHYS-1:0]             cur_q, cur_d;
    logic [NUM_PHYS-1:0]             com_q, com_d;
    logic [NUM_PHYS-1:0]             pend_q, pend_d;
    logic [NUM_PHYS-1:0]             free_vec;

    cam_mode_e mode;

    logic [LOOKUP_PORTS-1:0][ARCH_W-1:0] src_key;
    logic [LOOKUP_PORTS-1:0][PHYS_W-1:0] src_idx;
    logic [LOOKUP_PORTS-1:0]             src_err;

    logic              dst_err;
    logic [PHYS_W-1:0] cm_old;
    logic              cm_old_err;
    logic              cm_take;
    logic              rn_take;

    assign src_key[0] = lk_arch_a;
    assign src_key[1] = lk_arch_b;

    for (genvar p = 0; p < LOOKUP_PORTS; p++) begin : g_src
        rename_cam_match #(
            .NUM_ENTRIES (NUM_PHYS),
            .TAG_W       (ARCH_W),
            .IDX_W       (PHYS_W)
        ) u_src_match (
            .key  (src_key[p]),
            .tags (tag_q),
            .qual (cur_q),
            .idx  (src_idx[p]),
            .err  (src_err[p])
        );
    end

    assign lk_phys_a = src_idx[0];
    assign lk_phys_b = src_idx[1];
    assign lk_err_a  = src_err[0];
    assign lk_err_b  = src_err[1];

    rename_cam_match #(
        .NUM_ENTRIES (NUM_PHYS),
        .TAG_W       (ARCH_W),
        .IDX_W       (PHYS_W)
    ) u_dst_match (
        .key  (rn_arch),
        .tags (tag_q),
        .qual (cur_q),
        .idx  (rn_prev_phys),
        .err  (dst_err)
    );

    rename_cam_match #(
        .NUM_ENTRIES (NUM_PHYS),
        .TAG_W       (ARCH_W),
        .IDX_W       (PHYS_W)
    ) u_ret_match (
        .key  (tag_q[cm_phys]),
        .tags (tag_q),
        .qual (com_q),
        .idx  (cm_old),
        .err  (cm_old_err)
    );

    assign free_vec = ~(cur_q | com_q | pend_q);

    rename_cam_free_scan #(
        .NUM_ENTRIES (NUM_PHYS),
        .IDX_W       (PHYS_W)
    ) u_free_scan (
        .avail (free_vec),
        .found (rn_ok),
        .idx   (rn_phys)
    );

    assign mode    = recover ? MODE_ROLLBACK : MODE_NORMAL;
    assign rn_take = rn_valid && rn_ok && !dst_err;
    assign cm_take = cm_valid && pend_q[cm_phys] && !cm_old_err;

    always_comb begin
        tag_d  = tag_q;
        cur_d  = cur_q;
        com_d  = com_q;
        pend_d = pend_q;
        unique case (mode)
            MODE_ROLLBACK: begin
                cur_d  = com_q;
                pend_d = '0;
            end
            MODE_NORMAL: begin
                if (rn_take) begin
                    cur_d[rn_prev_phys] = 1'b0;
                    cur_d[rn_phys]      = 1'b1;
                    pend_d[rn_phys]     = 1'b1;
                    tag_d[rn_phys]      = rn_arch;
                end
                if (cm_take) begin
                    com_d[cm_old]   = 1'b0;
                    com_d[cm_phys]  = 1'b1;
                    pend_d[cm_phys] = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                tag_q[i]  <= (i < NUM_ARCH) ? ARCH_W'(i) : '0;
                cur_q[i]  <= (i < NUM_ARCH);
                com_q[i]  <= (i < NUM_ARCH);
                pend_q[i] <= 1'b0;
            end
        end else begin
            tag_q  <= tag_d;
            cur_q  <= cur_d;
            com_q  <= com_d;
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/rename_cam_table_chk.sv
module rename_cam_table_chk #(
    parameter int NUM_PHYS = 16,
    parameter int NUM_ARCH = 8,
    parameter int PHYS_W   = $clog2(NUM_PHYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PHYS-1:0] cur_q,
    input logic [NUM_PHYS-1:0] com_q,
    input logic [NUM_PHYS-1:0] pend_q,
    input logic                lk_err_a,
    input logic                lk_err_b,
    input logic                rn_valid,
    input logic                rn_ok,
    input logic [PHYS_W-1:0]   rn_phys,
    input logic                cm_valid,
    input logic [PHYS_W-1:0]   cm_phys,
    input logic                recover
);

    p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_err_a && !lk_err_b);

    p_cur_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cur_q) == NUM_ARCH);

    p_com_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(com_q) == NUM_ARCH);

    p_rename_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid && rn_ok && !recover) |=> pend_q[$past(rn_phys)]);

    p_retire_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && pend_q[cm_phys] && !recover) |=> com_q[$past(cm_phys)]);

    p_rollback_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> (cur_q == $past(com_q)) && (pend_q == '0));

    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rn_ok && !recover) |=> $stable(cur_q));

    p_retire_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!recover && !(cm_valid && pend_q[cm_phys])) |=> $stable(com_q));

endmodule

bind rename_cam_table rename_cam_table_chk #(
    .NUM_PHYS (NUM_PHYS),
    .NUM_ARCH (NUM_ARCH),
    .PHYS_W   (PHYS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_q    (cur_q),
    .com_q    (com_q),
    .pend_q   (pend_q),
    .lk_err_a (lk_err_a),
    .lk_err_b (lk_err_b),
    .rn_valid (rn_valid),
    .rn_ok    (rn_ok),
    .rn_phys  (rn_phys),
    .cm_valid (cm_valid),
    .cm_phys  (cm_phys),
    .recover  (recover)
);

// File: tb/rename_cam_table_bench.sv
module rename_cam_table_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;
    localparam int NA = 8;
    localparam int AW = 3;
    localparam int PW = 4;

    localparam logic [7:0] OP_RN  = 8'd1;
    localparam logic [7:0] OP_CM  = 8'd2;
    localparam logic [7:0] OP_RB  = 8'd3;

    // {op, arg, expected rn_phys, expected rn_prev_phys}
    localparam int NVEC = 9;
    localparam logic [31:0] VEC [NVEC] = '{
        {OP_RN, 8'd1,  8'd8,  8'd1},
        {OP_RN, 8'd2,  8'd9,  8'd2},
        {OP_RN, 8'd1,  8'd10, 8'd8},
        {OP_RN, 8'd6,  8'd11, 8'd6},
        {OP_CM, 8'd8,  8'd0,  8'd0},
        {OP_RN, 8'd3,  8'd1,  8'd3},
        {OP_CM, 8'd10, 8'd0,  8'd0},
        {OP_RN, 8'd4,  8'd8,  8'd4},
        {OP_RB, 8'd0,  8'd0,  8'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lk_arch_a = '0;
    logic [AW-1:0] lk_arch_b = '0;
    logic [PW-1:0] lk_phys_a, lk_phys_b;
    logic          lk_err_a, lk_err_b;
    logic          rn_valid = 1'b0;
    logic [AW-1:0] rn_arch = '0;
    logic          rn_ok;
    logic [PW-1:0] rn_phys, rn_prev_phys;
    logic          cm_valid = 1'b0;
    logic [PW-1:0] cm_phys = '0;
    logic          recover = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_cam_table #(.NUM_PHYS(NP), .NUM_ARCH(NA)) u_rename_cam_table (
        .clk, .rst_n, .lk_arch_a, .lk_arch_b, .lk_phys_a, .lk_phys_b,
        .lk_err_a, .lk_err_b, .rn_valid, .rn_arch, .rn_ok, .rn_phys,
        .rn_prev_phys, .cm_valid, .cm_phys, .recover
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic lookup(input string req, input int arch, input int exp);
        lk_arch_a = AW'(arch);
        lk_arch_b = AW'((arch + 1) % NA);
        #1;
        chk(req, int'(lk_phys_a), exp);
        chk({req, " err"}, int'(lk_err_a) + int'(lk_err_b), 0);
    endtask

    // drive at negedge, one rising edge, return at next negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        rn_valid = 1'b0;
        cm_valid = 1'b0;
        recover  = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int nalloc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < NA; a++) lookup("R1 reset map", a, a);
        chk("R1 rn_ok", int'(rn_ok), 1);
        chk("R1 first free", int'(rn_phys), NA);

        // table of renames, retirements, rollback (R3 R5 R6)
        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v][31:24])
                OP_RN: begin
                    rn_valid = 1'b1;
                    rn_arch  = AW'(VEC[v][23:16]);
                    #1;
                    chk("R3 R5 R6 rn_phys", int'(rn_phys), int'(VEC[v][15:8]));
                    chk("R3 rn_prev_phys", int'(rn_prev_phys), int'(VEC[v][7:0]));
                end
                OP_CM: begin
                    cm_valid = 1'b1;
                    cm_phys  = PW'(VEC[v][23:16]);
                end
                default: recover = 1'b1;
            endcase
            tick();
            if (v == 3) lookup("R3 new map", 1, 10);
        end

        // R7 after rollback: retired mappings visible
        lookup("R7 a1", 1, 10);
        lookup("R7 a2", 2, 2);
        lookup("R7 a3", 3, 3);
        lookup("R7 a4", 4, 4);
        lookup("R7 a6", 6, 6);
        chk("R7 freed lowest", int'(rn_phys), 1);

        // R8 fill the table with renames of register 0
        nalloc = 0;
        for (int k = 0; k < 20; k++) begin
            #1;
            if (rn_ok) begin
                rn_valid = 1'b1;
                rn_arch  = '0;
                nalloc++;
                tick();
            end
        end
        chk("R8 free count", nalloc, 8);
        chk("R8 rn_ok low", int'(rn_ok), 0);
        lookup("R8 before", 0, 15);
        rn_valid = 1'b1;
        rn_arch  = 3'd0;
        tick();
        lookup("R8 no change", 0, 15);
        lookup("R8 other", 5, 5);

        // R7 rollback with a rename in the same cycle
        recover  = 1'b1;
        rn_valid = 1'b1;
        rn_arch  = 3'd5;
        tick();
        lookup("R7 a0 back", 0, 0);
        lookup("R7 rename ignored", 5, 5);
        chk("R7 rn_ok", int'(rn_ok), 1);

        // R9 retire a stale entry that is not in flight, tagged register 0
        cm_valid = 1'b1;
        cm_phys  = 4'd12;
        tick();
        recover = 1'b1;
        tick();
        lookup("R9 stale retire", 0, 0);

        // R4 same-cycle lookup and rename
        rn_valid  = 1'b1;
        rn_arch   = 3'd3;
        lk_arch_a = 3'd3;
        #1;
        chk("R4 old map", int'(lk_phys_a), 3);
        chk("R4 rn_phys", int'(rn_phys), 1);
        tick();
        lookup("R4 new map", 3, 1);

        // R6 retire it, then the old entry 3 becomes free
        cm_valid = 1'b1;
        cm_phys  = 4'd1;
        tick();
        #1;
        chk("R6 old freed", int'(rn_phys), 3);
        recover = 1'b1;
        tick();
        lookup("R6 retired map", 3, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule